// File: doc/BRIEF.md
# ADC Serial Output Framer

This block turns 14-bit converter samples into a bit-serial stream on one or two data lanes, together with a frame marker and a data clock suitable for a double-data-rate receiver. Everything runs from one bit-rate clock: each clock cycle carries one bit on each active lane, and the data clock toggles once per bit, so its period is two bit-clock cycles.

A staged configuration selects one or two lanes, a word width of 16, 14 or 12 bits, and offset-binary or two's-complement coding. Samples arrive with a one-cycle strobe; at every sample-slot boundary the framer takes the most recent sample and shifts it out MSB first. In two-lane 14-bit operation a frame spans two sample slots, so the frame marker runs at half the sample rate. In every other mode one frame carries one sample.

A sequencer with three states drives the timing. `ST_IDLE` holds all outputs low after reset. The first strobe takes it to `ST_SLOT_A` (first slot of a frame). At the end of a slot, `ST_SLOT_A` goes to `ST_SLOT_B` when the active mode uses two-slot frames, or starts a new frame in `ST_SLOT_A` otherwise. `ST_SLOT_B` always returns to `ST_SLOT_A` at the end of its slot, and that is a frame start.

Top module: `adcf_top`

## Requirements
- R1: After synchronous reset `lane_a`, `lane_b`, `frame` and `dclk` are 0 and stay 0 until the first `samp_valid`. The first bit of the first frame appears in the cycle after that strobe. Reset also restores the default configuration: two lanes, 16 bits, offset binary.
- R2: Mode encoding: `ctl_two_lane`=1 selects two lanes and 0 selects one lane. `ctl_width` 00 selects 16 bits, 01 selects 14 bits, and 10 or 11 select 12 bits. A sample slot lasts W bit-clock cycles on one lane and W/2 cycles on two lanes.
- R3: Word bits are sent MSB first. In one-lane modes all bits go on `lane_a` and `lane_b` is held at 0.
- R4: In two-lane modes each cycle carries one pair of bits. `lane_a` carries the bit at the odd index of the word (W-1, W-3, … 1) and `lane_b` carries the even index just below it.
- R5: A 16-bit word is the 14-bit code followed by two zero bits. A 12-bit word is the upper 12 bits of the code.
- R6: With `ctl_twos`=0 the code equals the sample, which is offset binary. With `ctl_twos`=1 the sample MSB is inverted, so midscale 0x2000 becomes 0 and full scale 0x3FFF becomes 0x1FFF.
- R7: `frame` is high for the first half of each frame and low for the second half, and it rises with the first bit of the frame. The frame length is 14 cycles (two samples) in two-lane 14-bit mode and one slot in every other mode.
- R8: While running, `dclk` is 1 on even bit positions within the frame, counting from 0, and 0 on odd ones. It toggles every cycle and has a period of two cycles.
- R9: A configuration is captured on `ctl_load` and applied only at the next frame start. The frame in progress keeps its mode and coding.
- R10: Each slot carries the latest strobed sample. A strobe in the cycle that ends a slot feeds the next slot directly. If no new strobe arrives, the previous sample is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | One-cycle sample strobe |
| samp_data | input | 14 | Converter sample, offset binary |
| ctl_load | input | 1 | Captures the three control inputs |
| ctl_two_lane | input | 1 | 1 = two lanes, 0 = one lane |
| ctl_width | input | 2 | Word width select (00=16, 01=14, 1x=12) |
| ctl_twos | input | 1 | 1 = two's-complement coding |
| lane_a | output | 1 | Serial data lane A |
| lane_b | output | 1 | Serial data lane B |
| frame | output | 1 | Frame marker |
| dclk | output | 1 | Data clock, half the bit rate |

## Verification
Two events can land in the same cycle: a sample strobe on the cycle that closes a slot, and a configuration load on the cycle that closes a frame. The bench provokes the first by strobing at intervals equal to the slot length, so that every strobe after the first coincides with a slot end. It provokes the second by issuing `ctl_load` at arbitrary points in the running stream, with strobe gaps that are shorter than, equal to and longer than a slot. A behavioural model judges both cases on every cycle. It forwards a coincident sample into the new slot and applies a coincident load only to the frame after next. Lane bits, frame level, data-clock level, recovered words and frame spacing are all compared against the model.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    localparam int SAMP_W = 14;
    localparam int WORD_W = 16;
    localparam int PAD_W  = WORD_W - SAMP_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        WID_16  = 2'b00,
        WID_14  = 2'b01,
        WID_12  = 2'b10,
        WID_12X = 2'b11
    } width_e;

    typedef struct packed {
        logic   two_lane;
        width_e width;
        logic   twos;
    } cfg_t;

    localparam cfg_t CFG_RST = '{two_lane: 1'b1, width: WID_16, twos: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SLOT_A = 2'b01,
        ST_SLOT_B = 2'b10
    } state_e;

    // last counter value of a sample slot (slot length minus one)
    function automatic logic [CNT_W-1:0] slot_last(cfg_t c);
        logic [CNT_W:0] n;
        unique case (c.width)
            WID_16:  n = (CNT_W+1)'(16);
            WID_14:  n = (CNT_W+1)'(14);
            default: n = (CNT_W+1)'(12);
        endcase
        if (c.two_lane) n = n >> 1;
        return CNT_W'(n - (CNT_W+1)'(1));
    endfunction

    // two-lane 14-bit frames span two sample slots
    function automatic logic pair_frame(cfg_t c);
        return c.two_lane && (c.width == WID_14);
    endfunction

endpackage

// File: rtl/adcf_cfg.sv
module adcf_cfg
    import adcf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_load,
    input  cfg_t ctl_cfg,
    input  logic frame_start,
    output cfg_t act_cfg,
    output cfg_t next_cfg
);

    cfg_t pend_q;
    cfg_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CFG_RST;
            act_q  <= CFG_RST;
        end else begin
            if (ctl_load)    pend_q <= ctl_cfg;
            if (frame_start) act_q  <= pend_q;
        end
    end

    assign act_cfg  = act_q;
    assign next_cfg = frame_start ? pend_q : act_q;

endmodule

// File: rtl/adcf_coder.sv
module adcf_coder
    import adcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_valid,
    input  logic [SAMP_W-1:0] samp_data,
    input  logic              twos,
    output logic [WORD_W-1:0] word
);

    logic [SAMP_W-1:0] hold_q;
    logic [SAMP_W-1:0] pick;
    logic [SAMP_W-1:0] coded;

    always_ff @(posedge clk) begin
        if (rst)             hold_q <= '0;
        else if (samp_valid) hold_q <= samp_data;
    end

    always_comb begin
        pick  = samp_valid ? samp_data : hold_q;
        coded = pick;
        coded[SAMP_W-1] = pick[SAMP_W-1] ^ twos;
        word  = {coded, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/adcf_seq.sv
module adcf_seq
    import adcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_valid,
    input  cfg_t              act_cfg,
    input  logic [WORD_W-1:0] word_in,
    output logic              frame_start,
    output logic              running,
    output logic              lane_a,
    output logic              lane_b,
    output logic              frame,
    output logic              dclk
);

    state_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] word_q;
    logic              slot_start;
    logic              slot_end;
    logic [CNT_W-1:0]  last;

    assign last     = slot_last(act_cfg);
    assign slot_end = (cnt_q == last);

    // next-state and event decode
    always_comb begin
        state_d     = state_q;
        frame_start = 1'b0;
        slot_start  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (samp_valid) begin
                    state_d     = ST_SLOT_A;
                    frame_start = 1'b1;
                end
            end
            ST_SLOT_A: begin
                if (slot_end) begin
                    if (pair_frame(act_cfg)) begin
                        state_d    = ST_SLOT_B;
                        slot_start = 1'b1;
                    end else begin
                        frame_start = 1'b1;
                    end
                end
            end
            ST_SLOT_B: begin
                if (slot_end) begin
                    state_d     = ST_SLOT_A;
                    frame_start = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (frame_start || slot_start) cnt_d = '0;
        else if (state_q == ST_IDLE)   cnt_d = '0;
        else                           cnt_d = cnt_q + CNT_W'(1);
    end

    // state register, bit counter and word register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (frame_start || slot_start) word_q <= word_in;
        end
    end

    // outputs
    always_comb begin
        logic [IDX_W-1:0] step;
        logic [IDX_W-1:0] idx_a;
        logic [IDX_W:0]   half;
        logic             pos_odd;
        running = (state_q != ST_IDLE);
        step    = act_cfg.two_lane ? IDX_W'({cnt_q[CNT_W-2:0], 1'b0}) : IDX_W'(cnt_q);
        idx_a   = IDX_W'(WORD_W - 1) - step;
        half    = ({1'b0, last} + (IDX_W+1)'(1)) >> 1;
        pos_odd = cnt_q[0] ^ ((state_q == ST_SLOT_B) && !last[0]);
        lane_a  = 1'b0;
        lane_b  = 1'b0;
        frame   = 1'b0;
        dclk    = 1'b0;
        if (running) begin
            lane_a = word_q[idx_a];
            lane_b = act_cfg.two_lane ? word_q[idx_a - IDX_W'(1)] : 1'b0;
            dclk   = !pos_odd;
            if (state_q == ST_SLOT_A)
                frame = pair_frame(act_cfg) ? 1'b1 : ({1'b0, cnt_q} < half);
        end
    end

endmodule

// File: rtl/adcf_top.sv
module adcf_top
    import adcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_valid,
    input  logic [SAMP_W-1:0] samp_data,
    input  logic              ctl_load,
    input  logic              ctl_two_lane,
    input  logic [1:0]        ctl_width,
    input  logic              ctl_twos,
    output logic              lane_a,
    output logic              lane_b,
    output logic              frame,
    output logic              dclk
);

    cfg_t              ctl_cfg;
    cfg_t              act_cfg;
    cfg_t              next_cfg;
    logic              frame_start;
    logic              running;
    logic              one_lane;
    logic [WORD_W-1:0] word;

    assign ctl_cfg  = '{two_lane: ctl_two_lane, width: width_e'(ctl_width), twos: ctl_twos};
    assign one_lane = !act_cfg.two_lane;

    adcf_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .ctl_load    (ctl_load),
        .ctl_cfg     (ctl_cfg),
        .frame_start (frame_start),
        .act_cfg     (act_cfg),
        .next_cfg    (next_cfg)
    );

    adcf_coder u_coder (
        .clk        (clk),
        .rst        (rst),
        .samp_valid (samp_valid),
        .samp_data  (samp_data),
        .twos       (next_cfg.twos),
        .word       (word)
    );

    adcf_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .samp_valid  (samp_valid),
        .act_cfg     (act_cfg),
        .word_in     (word),
        .frame_start (frame_start),
        .running     (running),
        .lane_a      (lane_a),
        .lane_b      (lane_b),
        .frame       (frame),
        .dclk        (dclk)
    );

endmodule

// File: rtl/adcf_chk.sv
module adcf_chk (
    input logic clk,
    input logic rst,
    input logic samp_valid,
    input logic lane_a,
    input logic lane_b,
    input logic frame,
    input logic dclk,
    input logic running,
    input logic one_lane
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!lane_a && !lane_b && !frame && !dclk));

    a_r1_first_bit: assert property (@(posedge clk) disable iff (rst)
        (!running && samp_valid) |=> (running && frame && dclk));

    a_r8_dclk_toggle: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> (dclk != $past(dclk)));

    a_r7_frame_rise_on_dclk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame) |-> dclk);

    a_r3_lane_b_quiet: assert property (@(posedge clk) disable iff (rst)
        (running && one_lane) |-> !lane_b);

endmodule

bind adcf_top adcf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .lane_a     (lane_a),
    .lane_b     (lane_b),
    .frame      (frame),
    .dclk       (dclk),
    .running    (running),
    .one_lane   (one_lane)
);

// File: tb/adcf_top_test.sv
module adcf_top_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_valid = 1'b0;
    logic [13:0] samp_data = '0;
    logic        ctl_load = 1'b0;
    logic        ctl_two_lane = 1'b1;
    logic [1:0]  ctl_width = 2'b00;
    logic        ctl_twos = 1'b0;
    logic        lane_a, lane_b, frame, dclk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    adcf_top uut (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_data(samp_data),
        .ctl_load(ctl_load), .ctl_two_lane(ctl_two_lane), .ctl_width(ctl_width),
        .ctl_twos(ctl_twos), .lane_a(lane_a), .lane_b(lane_b), .frame(frame), .dclk(dclk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_run = 0;
    int m_cnt, m_S, m_slot, m_W, m_two, m_twos, m_flen, m_word, m_hold;
    int c_two = 1, c_w = 0, c_twos = 0;
    bit expA[16];
    bit expB[16];

    function automatic int width_of(input int code);
        if (code == 0) return 16;
        if (code == 1) return 14;
        return 12;
    endfunction

    task automatic build(input int s);
        int code, w, b;
        code = m_twos ? (s ^ 'h2000) : s;
        if (m_W == 16)      w = code << 2;
        else if (m_W == 14) w = code;
        else                w = code >> 2;
        m_word = w;
        for (int k = 0; k < 16; k++) begin expA[k] = 0; expB[k] = 0; end
        for (int k = 0; k < m_W; k++) begin
            b = (w >> (m_W - 1 - k)) & 1;
            if (m_two != 0) begin
                if (k % 2 == 0) expA[k/2] = b[0];
                else            expB[k/2] = b[0];
            end else begin
                expA[k] = b[0];
            end
        end
    endtask

    always @(posedge clk) begin
        bit sf, ss;
        sf = 0; ss = 0;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_slot = 0; m_hold = 0;
            c_two = 1; c_w = 0; c_twos = 0;
        end else begin
            if (!m_run) sf = samp_valid;
            else begin
                m_cnt++;
                if (m_cnt == m_S) begin
                    m_cnt = 0;
                    if (m_flen == 2*m_S && m_slot == 0) begin m_slot = 1; ss = 1; end
                    else sf = 1;
                end
            end
            if (sf) begin
                m_run = 1; m_slot = 0; m_cnt = 0;
                m_two = c_two; m_W = width_of(c_w); m_twos = c_twos;
                m_S = (m_two != 0) ? m_W/2 : m_W;
                m_flen = (m_two != 0 && m_W == 14) ? 2*m_S : m_S;
            end
            if (sf || ss) build(samp_valid ? int'(samp_data) : m_hold);
            if (samp_valid) m_hold = int'(samp_data);
            if (ctl_load) begin c_two = ctl_two_lane; c_w = ctl_width; c_twos = ctl_twos; end
        end
    end

    // ---------------- per-cycle comparison ----------------
    int rec, f_since, d_since, prev_flen;
    bit f_prev, d_prev, f_have, d_have;

    always @(negedge clk) begin
        int pos;
        if (!done && !rst) begin
            if (!m_run) begin
                chk(!lane_a && !lane_b && !frame && !dclk, "R1 idle outputs",
                    int'({lane_a, lane_b, frame, dclk}), 0);
                f_have = 0; d_have = 0; f_prev = 0; d_prev = 0;
            end else begin
                pos = m_slot*m_S + m_cnt;
                chk(lane_a == expA[m_cnt], "R3 R4 R5 R10 lane_a bit", int'(lane_a), int'(expA[m_cnt]));
                chk(lane_b == expB[m_cnt], "R3 R4 R5 R10 lane_b bit", int'(lane_b), int'(expB[m_cnt]));
                chk(frame == (pos < m_flen/2), "R7 frame level", int'(frame), int'(pos < m_flen/2));
                chk(dclk == (pos % 2 == 0), "R8 dclk level", int'(dclk), int'(pos % 2 == 0));
                if (m_cnt == 0) rec = 0;
                if (m_two != 0) rec = (rec << 2) | int'({lane_a, lane_b});
                else            rec = (rec << 1) | int'(lane_a);
                if (m_cnt == m_S - 1) chk(rec == m_word, "R2 R6 recovered word", rec, m_word);
                f_since++; d_since++;
                if (frame && !f_prev) begin
                    if (f_have) chk(f_since == prev_flen, "R7 R9 frame period", f_since, prev_flen);
                    f_have = 1; f_since = 0; prev_flen = m_flen;
                end
                if (dclk && !d_prev) begin
                    if (d_have) chk(d_since == 2, "R8 dclk period", d_since, 2);
                    d_have = 1; d_since = 0;
                end
                f_prev = frame; d_prev = dclk;
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [15:0] lfsr = 16'hACE1;
    int nsamp = 0;

    function automatic logic [13:0] next_sample();
        logic [13:0] v;
        case (nsamp % 40)
            0: v = 14'h2000;
            1: v = 14'h3FFF;
            2: v = 14'h0000;
            3: v = 14'h1FFF;
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v = lfsr[13:0];
            end
        endcase
        nsamp++;
        return v;
    endfunction

    task automatic run_mode(input int two, input int w, input int f, input int ncyc, input int gap);
        @(negedge clk);
        ctl_two_lane = two[0]; ctl_width = w[1:0]; ctl_twos = f[0]; ctl_load = 1;
        @(negedge clk);
        ctl_load = 0;
        for (int i = 0; i < ncyc; i++) begin
            samp_valid = (i % gap == 0);
            if (samp_valid) samp_data = next_sample();
            @(negedge clk);
        end
        samp_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!lane_a && !lane_b && !frame && !dclk, "R1 reset state",
            int'({lane_a, lane_b, frame, dclk}), 0);
        rst = 0;
        repeat (4) @(negedge clk);
        for (int two = 1; two >= 0; two--)
            for (int w = 0; w < 3; w++)
                for (int f = 0; f < 2; f++)
                    for (int g = 0; g < 3; g++) begin
                        int s;
                        s = width_of(w) / ((two != 0) ? 2 : 1);
                        run_mode(two, w, f, 90, (g == 0) ? s : (g == 1) ? 3 : 23);
                    end
        // reset in the middle of a running stream
        run_mode(1, 1, 1, 40, 7);
        rst = 1;
        @(negedge clk);
        chk(!lane_a && !lane_b && !frame && !dclk, "R1 reset clears outputs",
            int'({lane_a, lane_b, frame, dclk}), 0);
        rst = 0;
        repeat (5) @(negedge clk);
        // default configuration after reset: two lanes, 16 bits, offset binary
        samp_valid = 1; samp_data = 14'h2000;
        @(negedge clk);
        samp_valid = 0;
        repeat (20) @(negedge clk);
        run_mode(0, 2, 1, 80, 12);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule